// File: doc/BRIEF.md
# ASID-Tagged Multi-Way Translation Lookup

This block translates a 32-bit virtual address by searching every way of a small translation buffer at once. Four refill ways hold 4 KB pages; a fifth way holds large pages whose size is chosen at run time by a 2-bit code, which also moves the bits used to index it. Each entry stores a virtual page, a physical page, an 8-bit address-space tag and a 4-bit attribute. A tag counts as live only when it appears in one of the four bytes of the ring-tag register, and the byte position where it is found is the privilege ring of the mapping.

A request gives an address, an access kind (load, store, fetch or probe) and the current privilege level. One cycle after it is accepted, a registered response reports a cause code, the way and entry that hit, the ring and the physical address. Fetches and data accesses have separate cause codes for miss, multi-hit, privilege and rights faults. A probe reports only the outcome of the match, with no privilege or rights check. Entries are loaded through a write port that names the way and entry.

Top module: `tlbx_lookup`

## Requirements
- R1: The ring-tag register resets to 0x04030201 (ring i in byte i, byte 0 in bits 7:0). A write stores bits 31:8 of the written value and always sets bits 7:0 to 0x01.
- R2: An entry takes part in a match only if its tag is non-zero and equals one of the four ring-tag bytes. The reported ring is the lowest byte position holding that tag.
- R3: When entries in two or more ways match, the cause is 2 for a fetch and 6 for a load, store or probe. Way, entry, ring and physical address then read 0.
- R4: When no way matches, the cause is 1 for a fetch and 5 for a load, store or probe, with way, entry, ring and physical address reading 0.
- R5: Ways 0 to 3 use 4 KB pages, compare address bits 31:12 and take the entry index from address bits 13:12. A write whose entry number is not below the way depth (4), or whose way number is above 4, changes nothing.
- R6: Way 4 has a page of 1 MB shifted left by twice the size code; its index is the 2 address bits just above the page offset, and the size code in force applies both when an entry is written and when it is looked up.
- R7: On a single match, a load, store or fetch whose ring is numerically below the request privilege gets cause 3 (fetch) or 7 (data). This check comes before the rights check.
- R8: Attribute values below 12 allow read, with bit 0 adding execute and bit 1 adding write; value 13 allows read and write; all others allow nothing. A fetch needs execute (else cause 4), a load needs read (else cause 8), a store needs write (else cause 9); cause 0 means granted.
- R9: On a single match the physical address is the stored physical page (masked to the way's page) ORed with the address bits below the way's page boundary.
- R10: Access kind 3 (probe) returns cause 0 with way, entry, ring and address on a single match regardless of privilege and attribute; kinds 0, 1, 2 are load, store, fetch.
- R11: The response appears one cycle after a request is taken while req_valid and req_ready are both high; req_ready is high when no response is pending or rsp_ready is high, and a pending response stays unchanged while rsp_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rasid_we | input | 1 | Ring-tag register write strobe |
| rasid_wdata | input | 32 | Ring-tag register write value |
| rasid_o | output | 32 | Ring-tag register contents |
| var_size | input | 2 | Page-size code of way 4 |
| ent_we | input | 1 | Entry write strobe |
| ent_way | input | 3 | Way number written |
| ent_idx | input | 3 | Entry number written |
| ent_vaddr | input | 32 | Virtual page of the entry |
| ent_paddr | input | 32 | Physical page of the entry |
| ent_asid | input | 8 | Address-space tag of the entry |
| ent_attr | input | 4 | Attribute of the entry |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request can be taken |
| req_vaddr | input | 32 | Virtual address to translate |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch, 3 probe |
| req_priv | input | 2 | Current privilege level |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed |
| rsp_cause | output | 4 | Cause code, 0 on success |
| rsp_way | output | 3 | Way that matched |
| rsp_idx | output | 3 | Entry that matched |
| rsp_ring | output | 2 | Ring of the matching entry |
| rsp_paddr | output | 32 | Physical address |

## Verification
On every cycle the assertions check the handshake timing and response holding, that the forced low byte follows each ring-tag write, that a lookup with several matching ways yields a multi-hit cause and one with none yields a miss, and that no successful non-probe response carries a ring below the request privilege. The attribute decoding, the physical address arithmetic, the way-4 index movement with size code, and the effect of rewriting the ring-tag register on already loaded entries only show up in the bench's scenarios against its reference model.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;

    localparam int          VA_W             = 32;
    localparam int          TAG_W            = 8;
    localparam int          ATTR_W           = 4;
    localparam int          RING_N           = 4;
    localparam int          RING_W           = 2;
    localparam int          WAYNUM_W         = 3;
    localparam int          ENTNUM_W         = 3;
    localparam logic [31:0] RASID_RESET      = 32'h0403_0201;
    localparam logic [7:0]  RING0_TAG        = 8'h01;
    localparam int          SMALL_PAGE_SHIFT = 12;
    localparam int          BIG_PAGE_SHIFT   = 20;
    localparam logic [31:0] SMALL_PAGE_MASK  = 32'hFFFF_F000;
    localparam logic [31:0] BIG_PAGE_MASK    = 32'hFFF0_0000;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_PROBE = 2'd3
    } acc_kind_e;

    typedef enum logic [3:0] {
        CAUSE_OK         = 4'd0,
        CAUSE_I_MISS     = 4'd1,
        CAUSE_I_MULTI    = 4'd2,
        CAUSE_I_PRIV     = 4'd3,
        CAUSE_FETCH_DENY = 4'd4,
        CAUSE_D_MISS     = 4'd5,
        CAUSE_D_MULTI    = 4'd6,
        CAUSE_D_PRIV     = 4'd7,
        CAUSE_LOAD_DENY  = 4'd8,
        CAUSE_STORE_DENY = 4'd9
    } cause_e;

    typedef struct packed {
        logic [VA_W-1:0]   vpn;
        logic [VA_W-1:0]   ppn;
        logic [TAG_W-1:0]  tag;
        logic [ATTR_W-1:0] attr;
    } tlb_entry_t;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
    } rights_t;

    typedef struct packed {
        logic              found;
        logic [RING_W-1:0] ring;
    } ring_res_t;

    typedef struct packed {
        cause_e              cause;
        logic [WAYNUM_W-1:0] way;
        logic [ENTNUM_W-1:0] idx;
        logic [RING_W-1:0]   ring;
        logic [VA_W-1:0]     paddr;
    } lookup_rsp_t;

    // Attribute to access rights.
    function automatic rights_t decode_attr(logic [ATTR_W-1:0] a);
        rights_t r;
        r = '0;
        if (a < 4'd12) begin
            r.rd = 1'b1;
            r.ex = a[0];
            r.wr = a[1];
        end else if (a == 4'd13) begin
            r.rd = 1'b1;
            r.wr = 1'b1;
        end
        return r;
    endfunction

    // Tag to ring: lowest matching byte wins.
    function automatic ring_res_t resolve_ring(logic [31:0] rasid, logic [TAG_W-1:0] tag);
        ring_res_t r;
        r = '0;
        for (int i = RING_N - 1; i >= 0; i--) begin
            if (rasid[i*TAG_W +: TAG_W] == tag) begin
                r.found = 1'b1;
                r.ring  = RING_W'(i);
            end
        end
        return r;
    endfunction

    function automatic logic [VA_W-1:0] big_page_mask(logic [1:0] code);
        return BIG_PAGE_MASK << {code, 1'b0};
    endfunction

endpackage

// File: rtl/tlbx_ring_reg.sv
module tlbx_ring_reg
    import tlbx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic [31:0] wdata,
    output logic [31:0] rasid_o
);

    logic [31:0] rasid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rasid_q <= RASID_RESET;
        end else if (we) begin
            rasid_q <= {wdata[31:8], RING0_TAG};
        end
    end

    assign rasid_o = rasid_q;

    // R1
    ring0_forced_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> (rasid_o[7:0] == 8'h01) && (rasid_o[31:8] == $past(wdata[31:8])));

endmodule

// File: rtl/tlbx_way.sv
module tlbx_way
    import tlbx_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [VA_W-1:0]     page_mask,
    input  logic [4:0]          idx_shift,
    input  logic [31:0]         rasid,
    input  logic                wr_en,
    input  logic [ENTNUM_W-1:0] wr_idx,
    input  logic [VA_W-1:0]     wr_vaddr,
    input  logic [VA_W-1:0]     wr_paddr,
    input  logic [TAG_W-1:0]    wr_tag,
    input  logic [ATTR_W-1:0]   wr_attr,
    input  logic [VA_W-1:0]     lk_vaddr,
    output logic                hit_o,
    output logic [ENTNUM_W-1:0] idx_o,
    output logic [RING_W-1:0]   ring_o,
    output logic [VA_W-1:0]     ppn_o,
    output logic [ATTR_W-1:0]   attr_o
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    tlb_entry_t       ent_q [DEPTH];
    logic             wr_ok;
    logic [IDX_W-1:0] sel;
    tlb_entry_t       cur;
    ring_res_t        rr;

    assign wr_ok = wr_en && (int'(wr_idx) < DEPTH);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                ent_q[i] <= '0;
            end
        end else if (wr_ok) begin
            ent_q[wr_idx[IDX_W-1:0]] <= '{vpn:  wr_vaddr & page_mask,
                                          ppn:  wr_paddr & page_mask,
                                          tag:  wr_tag,
                                          attr: wr_attr};
        end
    end

    always_comb begin
        sel    = IDX_W'(lk_vaddr >> idx_shift);
        cur    = ent_q[sel];
        rr     = resolve_ring(rasid, cur.tag);
        hit_o  = (cur.tag != '0) && rr.found && (cur.vpn == (lk_vaddr & page_mask));
        idx_o  = ENTNUM_W'(sel);
        ring_o = rr.ring;
        ppn_o  = cur.ppn;
        attr_o = cur.attr;
    end

endmodule

// File: rtl/tlbx_resolve.sv
module tlbx_resolve
    import tlbx_pkg::*;
#(
    parameter int NW = 5
) (
    input  logic [NW-1:0]                hit,
    input  logic [NW-1:0][ENTNUM_W-1:0]  idx,
    input  logic [NW-1:0][RING_W-1:0]    ring,
    input  logic [NW-1:0][VA_W-1:0]      ppn,
    input  logic [NW-1:0][VA_W-1:0]      mask,
    input  logic [NW-1:0][ATTR_W-1:0]    attr,
    input  logic [VA_W-1:0]              vaddr,
    input  acc_kind_e                    kind,
    input  logic [RING_W-1:0]            priv,
    output lookup_rsp_t                  rsp_o
);

    int      nhit;
    int      sel;
    logic    data_side;
    rights_t rights;

    always_comb begin
        nhit = 0;
        sel  = 0;
        for (int w = NW - 1; w >= 0; w--) begin
            if (hit[w]) begin
                nhit = nhit + 1;
                sel  = w;
            end
        end
        data_side = (kind != ACC_FETCH);
        rights    = decode_attr(attr[sel]);
        rsp_o     = '0;
        if (nhit == 0) begin
            rsp_o.cause = data_side ? CAUSE_D_MISS : CAUSE_I_MISS;
        end else if (nhit > 1) begin
            rsp_o.cause = data_side ? CAUSE_D_MULTI : CAUSE_I_MULTI;
        end else begin
            rsp_o.way   = WAYNUM_W'(sel);
            rsp_o.idx   = idx[sel];
            rsp_o.ring  = ring[sel];
            rsp_o.paddr = ppn[sel] | (vaddr & ~mask[sel]);
            if (kind == ACC_PROBE) begin
                rsp_o.cause = CAUSE_OK;
            end else if (ring[sel] < priv) begin
                rsp_o.cause = data_side ? CAUSE_D_PRIV : CAUSE_I_PRIV;
            end else begin
                unique case (kind)
                    ACC_FETCH: rsp_o.cause = rights.ex ? CAUSE_OK : CAUSE_FETCH_DENY;
                    ACC_LOAD:  rsp_o.cause = rights.rd ? CAUSE_OK : CAUSE_LOAD_DENY;
                    default:   rsp_o.cause = rights.wr ? CAUSE_OK : CAUSE_STORE_DENY;
                endcase
            end
        end
    end

endmodule

// File: rtl/tlbx_lookup.sv
module tlbx_lookup
    import tlbx_pkg::*;
#(
    parameter int REFILL_WAYS  = 4,
    parameter int REFILL_DEPTH = 4,
    parameter int VAR_DEPTH    = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rasid_we,
    input  logic [31:0] rasid_wdata,
    output logic [31:0] rasid_o,
    input  logic [1:0]  var_size,
    input  logic        ent_we,
    input  logic [2:0]  ent_way,
    input  logic [2:0]  ent_idx,
    input  logic [31:0] ent_vaddr,
    input  logic [31:0] ent_paddr,
    input  logic [7:0]  ent_asid,
    input  logic [3:0]  ent_attr,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_vaddr,
    input  logic [1:0]  req_kind,
    input  logic [1:0]  req_priv,
    output logic        rsp_valid,
    input  logic        rsp_ready,
    output logic [3:0]  rsp_cause,
    output logic [2:0]  rsp_way,
    output logic [2:0]  rsp_idx,
    output logic [1:0]  rsp_ring,
    output logic [31:0] rsp_paddr
);

    localparam int NW = REFILL_WAYS + 1;

    logic [31:0]                   rasid;
    logic [NW-1:0]                 way_hit;
    logic [NW-1:0][ENTNUM_W-1:0]   way_idx;
    logic [NW-1:0][RING_W-1:0]     way_ring;
    logic [NW-1:0][VA_W-1:0]       way_ppn;
    logic [NW-1:0][VA_W-1:0]       way_mask;
    logic [NW-1:0][ATTR_W-1:0]     way_attr;
    lookup_rsp_t                   lk_rsp;
    lookup_rsp_t                   rsp_q;
    logic                          rsp_v_q;
    acc_kind_e                     kind_q;
    logic [RING_W-1:0]             priv_q;
    logic                          fire;

    tlbx_ring_reg u_ring (
        .clk     (clk),
        .rst     (rst),
        .we      (rasid_we),
        .wdata   (rasid_wdata),
        .rasid_o (rasid)
    );

    for (genvar w = 0; w < NW; w++) begin : g_way
        logic [VA_W-1:0] mask_w;
        logic [4:0]      shift_w;
        if (w == NW - 1) begin : g_var
            assign mask_w  = big_page_mask(var_size);
            assign shift_w = 5'(BIG_PAGE_SHIFT) + {2'b00, var_size, 1'b0};
        end else begin : g_fix
            assign mask_w  = SMALL_PAGE_MASK;
            assign shift_w = 5'(SMALL_PAGE_SHIFT);
        end

        tlbx_way #(
            .DEPTH ((w == NW - 1) ? VAR_DEPTH : REFILL_DEPTH)
        ) u_way (
            .clk       (clk),
            .rst       (rst),
            .page_mask (mask_w),
            .idx_shift (shift_w),
            .rasid     (rasid),
            .wr_en     (ent_we && (ent_way == WAYNUM_W'(w))),
            .wr_idx    (ent_idx),
            .wr_vaddr  (ent_vaddr),
            .wr_paddr  (ent_paddr),
            .wr_tag    (ent_asid),
            .wr_attr   (ent_attr),
            .lk_vaddr  (req_vaddr),
            .hit_o     (way_hit[w]),
            .idx_o     (way_idx[w]),
            .ring_o    (way_ring[w]),
            .ppn_o     (way_ppn[w]),
            .attr_o    (way_attr[w])
        );

        assign way_mask[w] = mask_w;
    end

    tlbx_resolve #(.NW(NW)) u_resolve (
        .hit   (way_hit),
        .idx   (way_idx),
        .ring  (way_ring),
        .ppn   (way_ppn),
        .mask  (way_mask),
        .attr  (way_attr),
        .vaddr (req_vaddr),
        .kind  (acc_kind_e'(req_kind)),
        .priv  (req_priv),
        .rsp_o (lk_rsp)
    );

    assign req_ready = !rsp_v_q || rsp_ready;
    assign fire      = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_v_q <= 1'b0;
            rsp_q   <= '0;
            kind_q  <= ACC_LOAD;
            priv_q  <= '0;
        end else if (fire) begin
            rsp_v_q <= 1'b1;
            rsp_q   <= lk_rsp;
            kind_q  <= acc_kind_e'(req_kind);
            priv_q  <= req_priv;
        end else if (rsp_ready) begin
            rsp_v_q <= 1'b0;
        end
    end

    assign rasid_o   = rasid;
    assign rsp_valid = rsp_v_q;
    assign rsp_cause = rsp_q.cause;
    assign rsp_way   = rsp_q.way;
    assign rsp_idx   = rsp_q.idx;
    assign rsp_ring  = rsp_q.ring;
    assign rsp_paddr = rsp_q.paddr;

    // R11
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        fire |=> rsp_valid);

    // R11
    rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_q));

    // R3
    multi_hit_cause_chk: assert property (@(posedge clk) disable iff (rst)
        fire && ($countones(way_hit) > 1) |=>
            (rsp_cause == CAUSE_I_MULTI) || (rsp_cause == CAUSE_D_MULTI));

    // R4
    miss_cause_chk: assert property (@(posedge clk) disable iff (rst)
        fire && (way_hit == '0) |=>
            (rsp_cause == CAUSE_I_MISS) || (rsp_cause == CAUSE_D_MISS));

    // R7
    ring_not_below_priv_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && (rsp_q.cause == CAUSE_OK) && (kind_q != ACC_PROBE) |->
            rsp_q.ring >= priv_q);

endmodule

// File: tb/tlbx_lookup_tb_top.sv
module tlbx_lookup_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        rasid_we;
    logic [31:0] rasid_wdata;
    logic [31:0] rasid_o;
    logic [1:0]  var_size;
    logic        ent_we;
    logic [2:0]  ent_way;
    logic [2:0]  ent_idx;
    logic [31:0] ent_vaddr;
    logic [31:0] ent_paddr;
    logic [7:0]  ent_asid;
    logic [3:0]  ent_attr;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_vaddr;
    logic [1:0]  req_kind;
    logic [1:0]  req_priv;
    logic        rsp_valid;
    logic        rsp_ready;
    logic [3:0]  rsp_cause;
    logic [2:0]  rsp_way;
    logic [2:0]  rsp_idx;
    logic [1:0]  rsp_ring;
    logic [31:0] rsp_paddr;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tlbx_lookup dut_i (.*);

    int n_chk  = 0;
    int n_fail = 0;
    logic monitor_on = 1'b0;
    logic exp_valid  = 1'b0;

    // reference state
    logic [31:0] m_vpn  [5][4];
    logic [31:0] m_ppn  [5][4];
    logic [7:0]  m_tag  [5][4];
    logic [3:0]  m_attr [5][4];
    logic [31:0] m_rasid;
    logic [1:0]  m_size;

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    function automatic logic [31:0] m_mask(int w, logic [1:0] c);
        if (w == 4) return 32'hFFF0_0000 << (2 * c);
        return 32'hFFFF_F000;
    endfunction

    function automatic int m_index(int w, logic [31:0] va, logic [1:0] c);
        if (w == 4) return int'((va >> (20 + 2 * c)) & 32'd3);
        return int'((va >> 12) & 32'd3);
    endfunction

    // expected {cause, way, idx, ring, paddr}
    function automatic logic [43:0] model(logic [31:0] va, logic [1:0] kind, logic [1:0] pr);
        int hits = 0;
        int hw = 0;
        int hi = 0;
        int hr = 0;
        logic fetch = (kind == 2'd2);
        logic [3:0] a;
        logic r, wr, x;
        logic [3:0] cause;
        logic [31:0] pa;
        for (int w = 0; w < 5; w++) begin
            int i = m_index(w, va, m_size);
            if (m_tag[w][i] != 8'h00 && m_vpn[w][i] == (va & m_mask(w, m_size))) begin
                int ring = -1;
                for (int b = 3; b >= 0; b--)
                    if (m_rasid[8*b +: 8] == m_tag[w][i]) ring = b;
                if (ring >= 0) begin
                    hits++;
                    hw = w;
                    hi = i;
                    hr = ring;
                end
            end
        end
        if (hits == 0) return {(fetch ? 4'd1 : 4'd5), 40'd0};
        if (hits > 1)  return {(fetch ? 4'd2 : 4'd6), 40'd0};
        a  = m_attr[hw][hi];
        r  = (a < 12) || (a == 13);
        wr = ((a < 12) && a[1]) || (a == 13);
        x  = (a < 12) && a[0];
        pa = m_ppn[hw][hi] | (va & ~m_mask(hw, m_size));
        if (kind == 2'd3)         cause = 4'd0;
        else if (hr < int'(pr))   cause = fetch ? 4'd3 : 4'd7;
        else if (kind == 2'd2)    cause = x  ? 4'd0 : 4'd4;
        else if (kind == 2'd0)    cause = r  ? 4'd0 : 4'd8;
        else                      cause = wr ? 4'd0 : 4'd9;
        return {cause, 3'(hw), 3'(hi), 2'(hr), pa};
    endfunction

    task automatic wr_raw(input int w, input int i, input logic [31:0] va, input logic [31:0] pa,
                          input logic [7:0] tag, input logic [3:0] at);
        @(negedge clk);
        ent_we = 1'b1; ent_way = 3'(w); ent_idx = 3'(i);
        ent_vaddr = va; ent_paddr = pa; ent_asid = tag; ent_attr = at;
        @(negedge clk);
        ent_we = 1'b0;
    endtask

    task automatic wr_ent(input int w, input logic [31:0] va, input logic [31:0] pa,
                          input logic [7:0] tag, input logic [3:0] at);
        int i = m_index(w, va, m_size);
        wr_raw(w, i, va, pa, tag, at);
        m_vpn[w][i]  = va & m_mask(w, m_size);
        m_ppn[w][i]  = pa & m_mask(w, m_size);
        m_tag[w][i]  = tag;
        m_attr[w][i] = at;
    endtask

    task automatic do_req(input logic [31:0] va, input logic [1:0] kind, input logic [1:0] pr, input string rq);
        logic [43:0] exp = model(va, kind, pr);
        @(negedge clk);
        req_vaddr = va; req_kind = kind; req_priv = pr; req_valid = 1'b1;
        @(posedge clk);
        #1 exp_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(rq, 64'({rsp_cause, rsp_way, rsp_idx, rsp_ring, rsp_paddr}), 64'(exp), "lookup");
        @(posedge clk);
        #1 exp_valid = 1'b0;
    endtask

    // per-cycle comparison of response valid
    always @(negedge clk) begin
        if (monitor_on) chk("R11", 64'(rsp_valid), 64'(exp_valid), "rsp_valid");
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [43:0] snap;
        for (int w = 0; w < 5; w++)
            for (int i = 0; i < 4; i++) begin
                m_vpn[w][i] = '0; m_ppn[w][i] = '0; m_tag[w][i] = '0; m_attr[w][i] = '0;
            end
        m_rasid = 32'h0403_0201;
        m_size  = 2'd0;
        rst = 1'b1; rasid_we = 1'b0; rasid_wdata = '0; var_size = 2'd0;
        ent_we = 1'b0; ent_way = '0; ent_idx = '0; ent_vaddr = '0; ent_paddr = '0;
        ent_asid = '0; ent_attr = '0; req_valid = 1'b0; req_vaddr = '0; req_kind = '0;
        req_priv = '0; rsp_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        monitor_on = 1'b1;

        // R1 reset value, R11 idle handshake
        chk("R1", 64'(rasid_o), 64'h0403_0201, "rasid reset");
        chk("R11", 64'(req_ready), 64'd1, "req_ready idle");

        // R4 empty buffer misses on both sides
        do_req(32'h1234_5678, 2'd0, 2'd0, "R4");
        do_req(32'h1234_5678, 2'd2, 2'd0, "R4");

        // R5 R9 single hit in refill way 0
        wr_ent(0, 32'h0000_1000, 32'h8000_0000, 8'h01, 4'h3);
        do_req(32'h0000_1ABC, 2'd0, 2'd0, "R9");
        do_req(32'h0000_1ABC, 2'd2, 2'd0, "R5");

        // R8 R7 R2 entry in ring 2 with attribute 5
        wr_ent(2, 32'h0040_3000, 32'h1234_5000, 8'h03, 4'h5);
        do_req(32'h0040_3010, 2'd1, 2'd0, "R8");
        do_req(32'h0040_3010, 2'd0, 2'd2, "R2");
        do_req(32'h0040_3010, 2'd0, 2'd3, "R7");
        do_req(32'h0040_3010, 2'd2, 2'd3, "R7");
        do_req(32'h0040_2000, 2'd0, 2'd0, "R5");

        // R10 probe ignores privilege
        do_req(32'h0040_3FFF, 2'd3, 2'd3, "R10");

        // R3 multi-hit across ways 0 and 1
        wr_ent(1, 32'h0000_1000, 32'h9000_0000, 8'h02, 4'h3);
        do_req(32'h0000_1004, 2'd0, 2'd0, "R3");
        do_req(32'h0000_1004, 2'd2, 2'd0, "R3");
        do_req(32'h0000_1004, 2'd3, 2'd0, "R10");

        // R8 attribute decoding
        wr_ent(3, 32'h0777_0000, 32'h0100_0000, 8'h04, 4'd13);
        do_req(32'h0777_0123, 2'd0, 2'd3, "R8");
        do_req(32'h0777_0123, 2'd1, 2'd3, "R8");
        do_req(32'h0777_0123, 2'd2, 2'd3, "R8");
        wr_ent(3, 32'h0777_0000, 32'h0100_0000, 8'h04, 4'd12);
        do_req(32'h0777_0123, 2'd0, 2'd0, "R8");
        wr_ent(3, 32'h0777_0000, 32'h0100_0000, 8'h04, 4'd14);
        do_req(32'h0777_0123, 2'd1, 2'd0, "R8");
        wr_ent(3, 32'h0777_0000, 32'h0100_0000, 8'h04, 4'd9);
        do_req(32'h0777_0123, 2'd2, 2'd0, "R8");
        do_req(32'h0777_0123, 2'd1, 2'd0, "R8");

        // R6 variable-size way
        wr_ent(4, 32'h3050_0000, 32'hA000_0000, 8'h01, 4'h3);
        do_req(32'h305A_BCDE, 2'd0, 2'd0, "R6");
        @(negedge clk);
        var_size = 2'd2; m_size = 2'd2;
        do_req(32'h305A_BCDE, 2'd0, 2'd0, "R6");
        wr_ent(4, 32'h4600_0000, 32'hB1FF_0000, 8'h01, 4'h3);
        do_req(32'h46AB_CDEF, 2'd0, 2'd0, "R6");

        // R1 write forces low byte; R2 tags re-resolved
        @(negedge clk);
        rasid_we = 1'b1; rasid_wdata = 32'h0A0B_0CFF;
        @(negedge clk);
        rasid_we = 1'b0;
        m_rasid = 32'h0A0B_0C01;
        chk("R1", 64'(rasid_o), 64'h0A0B_0C01, "rasid write");
        do_req(32'h0040_3000, 2'd0, 2'd0, "R2");
        do_req(32'h0000_1004, 2'd0, 2'd0, "R2");
        wr_ent(0, 32'h0000_2000, 32'h7000_0000, 8'h0C, 4'h3);
        do_req(32'h0000_2444, 2'd0, 2'd1, "R2");

        // R2 tag zero is invalid
        wr_ent(0, 32'h0000_1000, 32'h8000_0000, 8'h00, 4'h3);
        do_req(32'h0000_1004, 2'd0, 2'd0, "R2");

        // R5 out-of-range entry number and way number ignored
        wr_raw(0, 5, 32'h0000_1000, 32'h8000_0000, 8'h01, 4'h3);
        wr_raw(6, 1, 32'h0000_1000, 32'h8000_0000, 8'h01, 4'h3);
        do_req(32'h0000_1004, 2'd0, 2'd0, "R5");

        // R11 response held under back-pressure
        @(negedge clk);
        rsp_ready = 1'b0;
        snap = model(32'h46AB_CDEF, 2'd0, 2'd0);
        req_vaddr = 32'h46AB_CDEF; req_kind = 2'd0; req_priv = 2'd0; req_valid = 1'b1;
        @(posedge clk);
        #1 exp_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R11", 64'({rsp_cause, rsp_way, rsp_idx, rsp_ring, rsp_paddr}), 64'(snap), "held rsp");
        chk("R11", 64'(req_ready), 64'd0, "req_ready blocked");
        @(negedge clk);
        chk("R11", 64'({rsp_cause, rsp_way, rsp_idx, rsp_ring, rsp_paddr}), 64'(snap), "held rsp stable");
        chk("R11", 64'(req_ready), 64'd0, "req_ready still blocked");
        rsp_ready = 1'b1;
        @(posedge clk);
        #1 exp_valid = 1'b0;
        @(negedge clk);
        chk("R11", 64'(req_ready), 64'd1, "req_ready released");

        monitor_on = 1'b0;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule